// File: doc/BRIEF.md
# Four-Geometry Timer/Counter Channel

One timer/counter channel with two 8-bit count bytes. Each enabled count step comes from one of two sources. The first is an internal tick, produced once every `DIV` clocks (12 by default) by a free-running prescaler. The second is a falling edge on an external count pin. A 4-bit configuration field selects the counter geometry:

- a 13-bit counter, with a 5-bit prescaler held in the low byte;
- a 16-bit cascade of the two bytes;
- an 8-bit counter that reloads itself from the high byte;
- a split arrangement, in which the high byte runs as a second, independent 8-bit timer.

The configuration field also selects the count source and turns on gating by an external pin. With gating on, the width of a pulse on that pin can be measured.

Each geometry sets an overflow flag when its count wraps from all ones to all zeros. A flag stays set until an interrupt acknowledge or a software clear removes it. A processor writes either byte one byte at a time and reads either byte back through a byte-wide port. All control and status pins are plain levels or single-cycle strobes. There is no streaming interface, so there is no back-pressure.

Top module: `tc_channel`

## Requirements
- R1: After reset both count bytes read 0 and both overflow flags are 0.
- R2: A write strobe with `wr_sel`=0 loads `wr_data` into the low byte, and with `wr_sel`=1 into the high byte. The value is visible on the count outputs after the next clock edge. `rd_data` returns the low byte when `rd_sel`=0 and the high byte when `rd_sel`=1.
- R3: With `cfg[2]`=0 the channel counts internal ticks. The prescaler runs freely from reset, so any window of 12·k consecutive enabled clocks advances the count by exactly k.
- R4: The channel counts only while `run_a`=1 and either `cfg[3]`=0 or the 2-flop-synchronised `gate_pin` is 1. Otherwise the count bytes hold.
- R5: With `cfg[2]`=1, each 1-to-0 transition on `ext_cnt` advances the count once. The pin passes through a 2-flop synchroniser, so the byte changes on the third rising clock edge after the fall.
- R6: When `cfg[1:0]`=00 (13-bit), the low byte bits [4:0] form a prescaler that carries into the high byte. Low byte bits [7:5] keep the written value. The flag `flag_a` sets when the high byte is FF and the prescaler is 1F.
- R7: When `cfg[1:0]`=01 (16-bit), the high and low bytes count as one 16-bit value. `flag_a` sets on the wrap from FFFF to 0000.
- R8: When `cfg[1:0]`=10 (auto-reload), only the low byte counts. A step taken from FF loads the high byte into the low byte and sets `flag_a`. The high byte does not change.
- R9: When `cfg[1:0]`=11 (split), the low byte counts under the rules of R3 to R5 and sets `flag_a` on its wrap. The high byte counts only internal ticks, only while `run_b`=1, ignoring `cfg[3:2]` and `gate_pin`, and sets `flag_b` on its wrap.
- R10: A flag stays set until `ack_x` or `clr_x` is pulsed, and reads 0 on the cycle after that pulse. If a set and a clear arrive in the same cycle, the set wins.
- R11: If a write and a count step hit the same byte in the same cycle, the written value wins. The other byte still updates from the step, computed on the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 4 | [3] gate enable, [2] source select (1 = external pin), [1:0] geometry |
| run_a | input | 1 | Run control for the main channel |
| run_b | input | 1 | Run control for the high byte in split geometry |
| gate_pin | input | 1 | External gate level (asynchronous) |
| ext_cnt | input | 1 | External count pin (asynchronous); counts on a falling edge |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Write target: 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Write value |
| rd_sel | input | 1 | Read target: 0 = low byte, 1 = high byte |
| rd_data | output | 8 | Selected byte |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ack_a | input | 1 | Interrupt acknowledge, clears `flag_a` |
| ack_b | input | 1 | Interrupt acknowledge, clears `flag_b` |
| clr_a | input | 1 | Software clear of `flag_a` |
| clr_b | input | 1 | Software clear of `flag_b` |
| flag_a | output | 1 | Overflow flag of the main channel |
| flag_b | output | 1 | Overflow flag of the split high byte |

## Verification
Each kind of internal fault shows at the ports in a different place and after a different delay:

- **Prescaler phase or period.** A wrong value appears as a count that is off by one over a window that is a multiple of 12 clocks, within one prescaler period.
- **Edge detector or synchroniser.** A fault shows as a double count, a missed count, or a count that lands a cycle early or late. The bench samples that cycle exactly.
- **Carry and reload paths.** A fault surfaces at the boundaries 1F, FF and FFFF as a wrong byte and a missing or stray flag on the cycle after the wrap step.
- **Flag state.** A fault shows as a flag that drops while no clear is pending, or that survives an acknowledge by one cycle.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    TC_M13   = 2'b00,
    TC_M16   = 2'b01,
    TC_M8R   = 2'b10,
    TC_SPLIT = 2'b11
  } tc_mode_e;

  typedef struct packed {
    logic     gate_en;
    logic     ext_src;
    tc_mode_e mode;
  } tc_cfg_t;

endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tc_prescale.sv
module tc_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (DIV > 1) begin : g_chk
      // R3: internal ticks never come back to back
      assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core
  import tc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tc_mode_e          mode,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf_a,
  output logic              ovf_b
);
  localparam int CW = 2 * BYTE_W;

  logic [BYTE_W-1:0] nlo, nhi;
  logic [CW-1:0]     wide;

  always_comb begin
    nlo   = lo;
    nhi   = hi;
    ovf_a = 1'b0;
    ovf_b = 1'b0;
    wide  = {hi, lo} + {{(CW-1){1'b0}}, 1'b1};
    unique case (mode)
      TC_M13: if (tick_a) begin
        nlo[PRE_W-1:0] = lo[PRE_W-1:0] + {{(PRE_W-1){1'b0}}, 1'b1};
        if (&lo[PRE_W-1:0]) begin
          nhi   = hi + 1'b1;
          ovf_a = &hi;
        end
      end
      TC_M16: if (tick_a) begin
        {nhi, nlo} = wide;
        ovf_a      = &{hi, lo};
      end
      TC_M8R: if (tick_a) begin
        if (&lo) begin
          nlo   = hi;
          ovf_a = 1'b1;
        end else begin
          nlo = lo + 1'b1;
        end
      end
      TC_SPLIT: begin
        if (tick_a) begin
          nlo   = lo + 1'b1;
          ovf_a = &lo;
        end
        if (tick_b) begin
          nhi   = hi + 1'b1;
          ovf_b = &hi;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wr_data : nlo;
      hi <= wr_hi ? wr_data : nhi;
    end
  end

  // R4: with no step and no write, both bytes hold
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_a && !tick_b && !wr_lo && !wr_hi) |=> (lo == $past(lo) && hi == $past(hi)));

  // R6: upper bits of the low byte are untouched by 13-bit counting
  assert_upper_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TC_M13 && !wr_lo) |=> lo[BYTE_W-1:PRE_W] == $past(lo[BYTE_W-1:PRE_W]));

  // R8: reload byte is never altered by auto-reload counting
  assert_reload_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TC_M8R && !wr_hi) |=> hi == $past(hi));

  // R7: a 16-bit overflow leaves both bytes at zero unless written
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TC_M16 && ovf_a && !wr_lo && !wr_hi) |=> (lo == '0 && hi == '0));
endmodule

// File: rtl/tc_flag.sv
module tc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (set)        flag <= 1'b1;
    else if (ack || clr) flag <= 1'b0;
  end

  // R10: a set always lands
  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  // R10: a set flag persists while no clear is pending
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack && !clr) |=> flag);
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import tc_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PRE_W     = 5,
  parameter int DIV       = 12,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg,
  input  logic              run_a,
  input  logic              run_b,
  input  logic              gate_pin,
  input  logic              ext_cnt,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  input  logic              ack_a,
  input  logic              ack_b,
  input  logic              clr_a,
  input  logic              clr_b,
  output logic              flag_a,
  output logic              flag_b
);
  localparam int NFLAG = 2;

  tc_cfg_t cfg_s;
  assign cfg_s = tc_cfg_t'(cfg);

  logic int_tick, gate_s, ext_s, ext_prev, ext_fall;
  logic enable_a, tick_a, tick_b;
  logic ovf_a, ovf_b;

  tc_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(int_tick));

  tc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_gsync (
    .clk(clk), .rst_n(rst_n), .d(gate_pin), .q(gate_s));
  tc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_esync (
    .clk(clk), .rst_n(rst_n), .d(ext_cnt), .q(ext_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b1;
    else        ext_prev <= ext_s;
  end
  assign ext_fall = ext_prev & ~ext_s;

  assign enable_a = run_a & (~cfg_s.gate_en | gate_s);
  assign tick_a   = enable_a & (cfg_s.ext_src ? ext_fall : int_tick);
  assign tick_b   = (cfg_s.mode == TC_SPLIT) & run_b & int_tick;

  tc_count_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(cfg_s.mode),
    .tick_a(tick_a), .tick_b(tick_b),
    .wr_lo(wr_en & ~wr_sel), .wr_hi(wr_en & wr_sel), .wr_data(wr_data),
    .lo(cnt_lo), .hi(cnt_hi), .ovf_a(ovf_a), .ovf_b(ovf_b));

  logic [NFLAG-1:0] f_set, f_ack, f_clr, f_q;
  assign f_set = {ovf_b, ovf_a};
  assign f_ack = {ack_b, ack_a};
  assign f_clr = {clr_b, clr_a};

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      tc_flag u_flag (.clk(clk), .rst_n(rst_n), .set(f_set[i]),
                      .ack(f_ack[i]), .clr(f_clr[i]), .flag(f_q[i]));
    end
  endgenerate

  assign flag_a  = f_q[0];
  assign flag_b  = f_q[1];
  assign rd_data = rd_sel ? cnt_hi : cnt_lo;

  // R5: one falling edge yields one single-cycle step request
  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall |=> !ext_fall);
  // R9: the split high-byte flag only rises in split geometry
  assert_flagb_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) |-> $past(cfg_s.mode) == TC_SPLIT);
  // R4: a stopped channel never raises the main flag
  assert_stop_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_a && !flag_a) |=> !flag_a);
endmodule

// File: tb/tc_channel_test.sv
module tc_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {000, cfg[3:0], lo, hi, steps, exp_lo, exp_hi, exp_fa, exp_fb}
  localparam logic [63:0] VEC [NVEC] = '{
    64'h000_5_FE_00_03_01_01_0_0,  // R7
    64'h000_5_FF_FF_01_00_00_1_0,  // R7 wrap
    64'h000_5_FD_FF_05_02_00_1_0,  // R7 through wrap
    64'h000_4_FE_05_03_E1_06_0_0,  // R6 carry, upper bits kept
    64'h000_4_1F_FF_01_00_00_1_0,  // R6 wrap
    64'h000_4_A0_00_28_A8_01_0_0,  // R6 40 steps
    64'h000_6_FE_F0_03_F1_F0_1_0,  // R8 reload
    64'h000_6_10_80_04_14_80_0_0,  // R8 no reload
    64'h000_7_FF_33_02_01_33_1_0,  // R9 low byte split
    64'h000_6_FF_FF_02_FF_FF_1_0   // R8 reload of FF
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg = 4'h0;
  logic run_a = 0, run_b = 0, gate_pin = 0, ext_cnt = 1;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 8'h00;
  logic ack_a = 0, ack_b = 0, clr_a = 0, clr_b = 0;
  logic [7:0] rd_data, cnt_lo, cnt_hi;
  logic flag_a, flag_b;

  int checks = 0, fails = 0;
  bit done = 0;

  tc_channel uut (.clk(clk), .rst_n(rst_n), .cfg(cfg), .run_a(run_a), .run_b(run_b),
    .gate_pin(gate_pin), .ext_cnt(ext_cnt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi), .ack_a(ack_a), .ack_b(ack_b), .clr_a(clr_a), .clr_b(clr_b),
    .flag_a(flag_a), .flag_b(flag_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbyte(input logic sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_cnt = 0; cyc(3);
      ext_cnt = 1; cyc(3);
    end
    cyc(4);
  endtask

  task automatic clear_flags();
    clr_a = 1; clr_b = 1; cyc(1); clr_a = 0; clr_b = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 bytes", {cnt_hi, cnt_lo}, 16'h0000);
    chk("R1 flags", {14'd0, flag_b, flag_a}, 16'h0000);

    // R2 write / read
    wbyte(0, 8'h3C); wbyte(1, 8'hC3);
    rd_sel = 0; #1;
    chk("R2 rd lo", {8'h00, rd_data}, 16'h003C);
    rd_sel = 1; #1;
    chk("R2 rd hi", {8'h00, rd_data}, 16'h00C3);
    chk("R2 bytes", {cnt_hi, cnt_lo}, 16'hC33C);

    // vector table: external source, no gating (R5)
    for (int v = 0; v < NVEC; v++) begin
      run_a = 0;
      cfg = VEC[v][51:48];
      wbyte(0, VEC[v][47:40]); wbyte(1, VEC[v][39:32]);
      clear_flags();
      run_a = 1;
      pulses(int'(VEC[v][31:24]));
      run_a = 0;
      chk($sformatf("R5 vec%0d bytes", v), {cnt_hi, cnt_lo}, {VEC[v][15:8], VEC[v][23:16]});
      chk($sformatf("R10 vec%0d flags", v), {14'd0, flag_b, flag_a},
          {14'd0, VEC[v][0], VEC[v][4]});
    end

    // R3 internal source: 60 enabled clocks -> 5 steps
    cfg = 4'b0001; wbyte(0, 8'h00); wbyte(1, 8'h00); clear_flags();
    run_a = 1; cyc(60); run_a = 0; cyc(1);
    chk("R3 internal x5", {cnt_hi, cnt_lo}, 16'h0005);

    // R4 run off: pulses ignored
    cfg = 4'b0101; wbyte(0, 8'h20); wbyte(1, 8'h00);
    pulses(2);
    chk("R4 run off", {cnt_hi, cnt_lo}, 16'h0020);
    // R4 gate enabled, pin low: ignored
    cfg = 4'b1101; gate_pin = 0; run_a = 1; cyc(3);
    pulses(2);
    chk("R4 gate low", {cnt_hi, cnt_lo}, 16'h0020);
    // R4 gate pin high: counting resumes
    gate_pin = 1; cyc(3);
    pulses(3);
    chk("R4 gate high", {cnt_hi, cnt_lo}, 16'h0023);
    run_a = 0; gate_pin = 0;

    // R5 exact latency and R11 write priority on the same byte
    cfg = 4'b0101; wbyte(0, 8'h10); wbyte(1, 8'h20); run_a = 1; cyc(1);
    ext_cnt = 0;
    cyc(2);           // edges k, k+1 passed; step lands on k+2
    chk("R5 not yet", {cnt_hi, cnt_lo}, 16'h2010);
    wr_en = 1; wr_sel = 0; wr_data = 8'h55;
    cyc(1); wr_en = 0;
    chk("R11 write wins", {cnt_hi, cnt_lo}, 16'h2055);
    ext_cnt = 1; cyc(4);
    ext_cnt = 0; cyc(3);
    chk("R5 third edge", {cnt_hi, cnt_lo}, 16'h2056);
    ext_cnt = 1; cyc(3); run_a = 0;

    // R9 split: high byte on internal ticks under run_b, low gated off
    cfg = 4'b1111; gate_pin = 0; run_a = 1;
    wbyte(0, 8'h44); wbyte(1, 8'hFE); clear_flags();
    run_b = 1; cyc(36); run_b = 0; cyc(1);
    chk("R9 split hi", {cnt_hi, cnt_lo}, 16'h0144);
    chk("R9 flag_b", {14'd0, flag_b, flag_a}, 16'h0002);
    run_a = 0;

    // R10 hold and acknowledge / software clear
    cyc(10);
    chk("R10 hold", {15'd0, flag_b}, 16'h0001);
    ack_b = 1; cyc(1); ack_b = 0;
    chk("R10 ack_b", {15'd0, flag_b}, 16'h0000);
    cfg = 4'b0101; wbyte(0, 8'hFF); wbyte(1, 8'hFF); run_a = 1;
    pulses(1); run_a = 0;
    chk("R10 set", {15'd0, flag_a}, 16'h0001);
    ack_a = 1; cyc(1); ack_a = 0;
    chk("R10 ack_a", {15'd0, flag_a}, 16'h0000);
    wbyte(0, 8'hFF); wbyte(1, 8'hFF); run_a = 1;
    pulses(1); run_a = 0;
    clr_a = 1; cyc(1); clr_a = 0;
    chk("R10 clr_a", {15'd0, flag_a}, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule